// File: doc/BRIEF.md
# Two-Stage Reloadable Interval Timer

The block is a programmable interval timer made of two cascaded down-counters. A prescaler stage counts selected count-source ticks. Each time it passes zero it reloads itself and moves the main stage by one. When the main stage passes zero it also reloads, pulses a one-cycle underflow strobe and sets a sticky interrupt request flag. The count source is chosen from four options: every clock, every second clock, every eighth clock, or a single-cycle underflow pulse from a neighbouring timer.

Software reaches the block through a small register bus. The bus can write and read both stages, start and stop counting, pick the count source, pick the write mode and clear the request flag. While the timer is stopped, a write to a stage loads its counter and its reload value together. While it runs, the write mode decides what happens. In the immediate-reload mode only the reload value changes, and the counter takes it at its next natural reload. In the pipelined mode the new value moves in over three count-source ticks, and the write also raises the request flag.

Top module: `cascade_interval_timer`

## Requirements
- R1: Control bits [3:2] select the count source. Value 0 gives a tick on every clock. Value 1 gives a tick on every second clock. Value 2 gives a tick on every eighth clock. Value 3 gives a tick in each cycle that `ext_uf` is high. The two divided sources come from a free-running divider that is cleared by reset.
- R2: On each counting tick the prescaler decrements. When it is 0 it reloads from its reload register and produces an underflow, and only that underflow steps the main stage. When the main stage is 0 at that moment it reloads from its reload register, and `uf_strobe` is high for exactly the following cycle.
- R3: With prescaler setting n and main setting m, `uf_strobe` pulses once every (n+1)(m+1) count-source ticks.
- R4: Control bit 0 is the start bit. While it is 0 no stage changes on a tick and the counter values are held.
- R5: `irq_flag` sets on every main underflow and reads as control bit 4. A control write with bit 4 = 0 clears it. A control write with bit 4 = 1 leaves it unchanged. A set in the same cycle as a clear wins.
- R6: Bus address 0 reads the live prescaler count and address 1 reads the live main count, not the reload values. Address 2 reads the control bits {irq, source[1:0], mode, start} in bits [4:0]. Address 3 reads 0.
- R7: A write to address 0 or 1 while the start bit is 0 loads the value into that stage's counter and its reload register, both visible one cycle later.
- R8: A write to address 0 or 1 while running with control bit 1 (mode) = 0 is held in a pending slot. Both stages are frozen until the sequence ends. At the first later tick the value enters the reload register. At the second tick it is copied into the counter. At the third tick counting resumes, and that tick itself is counted. A new such write restarts the sequence, and the sequence does not advance in the cycle of the write.
- R9: A write to address 0 or 1 while running with mode = 1 changes only that stage's reload register. The counter keeps counting and takes the new value at its next reload.
- R10: Any write to address 0 or 1 while the start bit is 1 and mode is 0 sets `irq_flag` in the next cycle.
- R11: After reset both counters, both reload registers, all control bits and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_uf | input | 1 | Single-cycle underflow pulse from a neighbouring timer |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 prescaler, 1 main, 2 control) |
| bus_wdata | input | W (8) | Write data |
| bus_rdata | output | W (8) | Combinational read data for `bus_addr` |
| irq_flag | output | 1 | Sticky underflow interrupt request |
| uf_strobe | output | 1 | One-cycle pulse after each main underflow |

## Verification
The hardest situation to reach is the pipelined-write sequence while the timer runs. Its three steps wait on count-source ticks rather than clocks, so with a divided source they spread over many cycles. They also interact with reloads, with a second write that lands mid-sequence, and with the spurious request flag. The stimulus therefore issues pipelined writes under the every-clock source, issues back-to-back writes to both stages so that one restarts the other's sequence, and repeats this under the external-pulse source, where ticks arrive only when the bench pulses `ext_uf`. A behavioural model is compared on every clock, so each frozen, latched and resumed step is checked in the cycle it happens.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_LATCH  = 2'd1,
      SEQ_COPY   = 2'd2,
      SEQ_RESUME = 2'd3
   } seq_t;

   localparam int          N_STAGE   = 2;
   localparam logic [1:0]  ADDR_PRE  = 2'd0;
   localparam logic [1:0]  ADDR_MAIN = 2'd1;
   localparam logic [1:0]  ADDR_CTRL = 2'd2;
   localparam int          CTRL_BITS = 5;
endpackage

// File: rtl/ctm_tick_gen.sv
module ctm_tick_gen #(
   parameter int SLOW_DIV = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       ext_uf,
   output logic       tick
);
   localparam int DIV_W = $clog2(SLOW_DIV);

   generate
      if (SLOW_DIV < 4 || (SLOW_DIV & (SLOW_DIV - 1)) != 0) begin : g_bad_div
         $error("SLOW_DIV must be a power of two of at least 4");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   always_comb begin
      unique case (sel)
         2'd0:    tick = 1'b1;
         2'd1:    tick = div_q[0];
         2'd2:    tick = &div_q;
         default: tick = ext_uf;
      endcase
   end

   // R1
   half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd1 && tick) |=> (sel != 2'd1 || !tick));
   // R1
   slow_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd2 && tick) |=> (sel != 2'd2 || !tick));
endmodule

// File: rtl/ctm_stage.sv
module ctm_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         rl_we,
   input  logic [W-1:0] rl_d,
   input  logic         cnt_we,
   input  logic [W-1:0] cnt_d,
   input  logic         copy,
   output logic [W-1:0] cnt,
   output logic [W-1:0] rl,
   output logic         uf
);
   assign uf = en && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rl <= '0;
      else if (rl_we) rl <= rl_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (cnt_we)  cnt <= cnt_d;
      else if (copy)    cnt <= rl;
      else if (en)      cnt <= (cnt == '0) ? rl : cnt - 1'b1;
   end

   // R2
   reload_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt == '0 && !cnt_we && !copy) |=> cnt == $past(rl));
   // R4
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cnt_we && !copy) |=> $stable(cnt));
endmodule

// File: rtl/ctm_seq.sv
module ctm_seq
   import ctm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic tick_ok,
   output seq_t state,
   output logic latch_go,
   output logic copy_go
);
   assign latch_go = (state == SEQ_LATCH) && tick_ok;
   assign copy_go  = (state == SEQ_COPY)  && tick_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state <= SEQ_IDLE;
      else if (arm)     state <= SEQ_LATCH;
      else if (tick_ok) begin
         unique case (state)
            SEQ_LATCH:  state <= SEQ_COPY;
            SEQ_COPY:   state <= SEQ_RESUME;
            default:    state <= SEQ_IDLE;
         endcase
      end
   end

   // R8
   seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_COPY && !arm) |=> (state == SEQ_COPY || state == SEQ_RESUME));
endmodule

// File: rtl/cascade_interval_timer.sv
module cascade_interval_timer
   import ctm_pkg::*;
#(
   parameter int W        = 8,
   parameter int SLOW_DIV = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ext_uf,
   input  logic         bus_we,
   input  logic [1:0]   bus_addr,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   output logic         irq_flag,
   output logic         uf_strobe
);
   generate
      if (W < CTRL_BITS) begin : g_bad_w
         $error("W must hold the control bits");
      end
   endgenerate

   logic       start_q, mode_q;
   logic [1:0] src_q;
   logic       tick, count_en, arm, tick_ok, latch_go, copy_go, ctrl_wr;
   seq_t       seq_state;

   logic [N_STAGE-1:0][W-1:0] cnt, rl, pdat;
   logic [N_STAGE-1:0]        uf, en, pend, wr_s, direct, fast_rl, seq_wr;

   ctm_tick_gen #(.SLOW_DIV(SLOW_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .sel(src_q), .ext_uf(ext_uf), .tick(tick));

   assign ctrl_wr  = bus_we && (bus_addr == ADDR_CTRL);
   assign arm      = |seq_wr;
   assign tick_ok  = tick && start_q && !arm;
   assign count_en = tick && start_q &&
                     (seq_state == SEQ_IDLE || seq_state == SEQ_RESUME);

   ctm_seq u_seq (
      .clk(clk), .rst_n(rst_n), .arm(arm), .tick_ok(tick_ok),
      .state(seq_state), .latch_go(latch_go), .copy_go(copy_go));

   assign en[0] = count_en;
   assign en[1] = uf[0];

   generate
      for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
         logic         rl_we;
         logic [W-1:0] rl_d;

         assign wr_s[s]    = bus_we && (bus_addr == 2'(s));
         assign direct[s]  = wr_s[s] && !start_q;
         assign fast_rl[s] = wr_s[s] && start_q && mode_q;
         assign seq_wr[s]  = wr_s[s] && start_q && !mode_q;
         assign rl_we      = direct[s] || fast_rl[s] || (latch_go && pend[s]);
         assign rl_d       = (direct[s] || fast_rl[s]) ? bus_wdata : pdat[s];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend[s] <= 1'b0;
               pdat[s] <= '0;
            end else if (direct[s]) begin
               pend[s] <= 1'b0;
            end else if (seq_wr[s]) begin
               pend[s] <= 1'b1;
               pdat[s] <= bus_wdata;
            end else if (copy_go) begin
               pend[s] <= 1'b0;
            end
         end

         ctm_stage #(.W(W)) u_stage (
            .clk(clk), .rst_n(rst_n), .en(en[s]),
            .rl_we(rl_we), .rl_d(rl_d),
            .cnt_we(direct[s]), .cnt_d(bus_wdata),
            .copy(copy_go && pend[s]),
            .cnt(cnt[s]), .rl(rl[s]), .uf(uf[s]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= 1'b0;
         mode_q    <= 1'b0;
         src_q     <= 2'd0;
         irq_flag  <= 1'b0;
         uf_strobe <= 1'b0;
      end else begin
         uf_strobe <= uf[1];
         if (ctrl_wr) begin
            start_q <= bus_wdata[0];
            mode_q  <= bus_wdata[1];
            src_q   <= bus_wdata[3:2];
         end
         if (uf[1] || arm)              irq_flag <= 1'b1;
         else if (ctrl_wr && !bus_wdata[4]) irq_flag <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_PRE:  bus_rdata = cnt[0];
         ADDR_MAIN: bus_rdata = cnt[1];
         ADDR_CTRL: bus_rdata[CTRL_BITS-1:0] = {irq_flag, src_q, mode_q, start_q};
         default:   bus_rdata = '0;
      endcase
   end

   // R5
   strobe_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_strobe |-> irq_flag);
   // R10
   spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[1] == 1'b0 && start_q && !mode_q) |=> irq_flag);
   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_strobe && $past(rl[1]) != '0 && $past(rl[0]) != '0) |=> !uf_strobe);
endmodule

// File: tb/cascade_interval_timer_tb.sv
module cascade_interval_timer_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ext_uf = 1'b0;
   logic         bus_we = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         irq_flag, uf_strobe;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cascade_interval_timer #(.W(W), .SLOW_DIV(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_uf(ext_uf), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_flag(irq_flag), .uf_strobe(uf_strobe));

   // behavioural reference state
   int m_cnt[2], m_rl[2], m_pd[2];
   bit m_pend[2];
   int m_seq, m_div, m_src;
   bit m_start, m_mode, m_irq, m_ufs;

   function automatic int model_read(int a);
      case (a)
         0: return m_cnt[0];
         1: return m_cnt[1];
         2: return (int'(m_irq) << 4) | (m_src << 2) | (int'(m_mode) << 1) | int'(m_start);
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = '{0, 0}; m_rl = '{0, 0}; m_pd = '{0, 0}; m_pend = '{0, 0};
         m_seq = 0; m_div = 0; m_src = 0;
         m_start = 0; m_mode = 0; m_irq = 0; m_ufs = 0;
      end else begin
         int n_cnt[2], n_rl[2], n_pd[2], n_seq, a;
         bit n_pend[2], tk, cen, seqw, muf, n_irq;
         n_cnt = m_cnt; n_rl = m_rl; n_pd = m_pd; n_pend = m_pend; n_seq = m_seq;
         a = int'(bus_addr);
         case (m_src)
            0: tk = 1;
            1: tk = (m_div % 2) == 1;
            2: tk = (m_div == 7);
            default: tk = ext_uf;
         endcase
         seqw = bus_we && a < 2 && m_start && !m_mode;
         cen = tk && m_start && (m_seq == 0 || m_seq == 3);
         muf = 0;
         if (cen) begin
            if (m_cnt[0] == 0) begin
               n_cnt[0] = m_rl[0];
               if (m_cnt[1] == 0) begin n_cnt[1] = m_rl[1]; muf = 1; end
               else n_cnt[1] = m_cnt[1] - 1;
            end else n_cnt[0] = m_cnt[0] - 1;
         end
         if (tk && m_start && !seqw) begin
            case (m_seq)
               1: begin
                  for (int s = 0; s < 2; s++) if (m_pend[s]) n_rl[s] = m_pd[s];
                  n_seq = 2;
               end
               2: begin
                  for (int s = 0; s < 2; s++) if (m_pend[s]) begin
                     n_cnt[s] = m_rl[s]; n_pend[s] = 0;
                  end
                  n_seq = 3;
               end
               default: n_seq = 0;
            endcase
         end
         n_irq = m_irq;
         if (bus_we && a < 2) begin
            if (!m_start) begin
               n_rl[a] = int'(bus_wdata); n_cnt[a] = int'(bus_wdata); n_pend[a] = 0;
            end else if (m_mode) begin
               n_rl[a] = int'(bus_wdata);
            end else begin
               n_pd[a] = int'(bus_wdata); n_pend[a] = 1; n_seq = 1;
            end
         end
         if (bus_we && a == 2) begin
            m_start = bus_wdata[0]; m_mode = bus_wdata[1]; m_src = int'(bus_wdata[3:2]);
            if (!bus_wdata[4]) n_irq = 0;
         end
         if (muf || seqw) n_irq = 1;
         m_irq = n_irq; m_ufs = muf;
         m_cnt = n_cnt; m_rl = n_rl; m_pd = n_pd; m_pend = n_pend; m_seq = n_seq;
         m_div = (m_div + 1) % 8;
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(int'(bus_rdata) == model_read(int'(bus_addr)),
             bus_addr == 2'd2 ? "R6 control readback" : "R6 counter readback",
             int'(bus_rdata), model_read(int'(bus_addr)));
         chk(irq_flag == m_irq, "R5 irq_flag", int'(irq_flag), int'(m_irq));
         chk(uf_strobe == m_ufs, "R2 uf_strobe", int'(uf_strobe), int'(m_ufs));
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk); #1;
      bus_we = 1; bus_addr = 2'(a); bus_wdata = W'(d);
      @(negedge clk); #1;
      bus_we = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         bus_addr = 2'(i % 3);
      end
   endtask

   task automatic pulse_ext(int n, int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1; ext_uf = 1; bus_addr = 2'(i % 3);
         @(negedge clk); #1; ext_uf = 0;
         idle(gap);
      end
   endtask

   task automatic peek(int a, output int v);
      @(negedge clk); #1; bus_addr = 2'(a);
      #1; v = int'(bus_rdata);
   endtask

   task automatic gap_chk(int exp, string req);
      int c;
      c = 0;
      @(negedge clk);
      while (!uf_strobe) @(negedge clk);
      @(negedge clk);
      while (!uf_strobe) begin c++; @(negedge clk); end
      chk(c + 1 == exp, req, c + 1, exp);
   endtask

   initial begin
      int v, v2;
      repeat (4) @(negedge clk);
      // R11 reset state
      for (int a = 0; a < 4; a++) begin
         bus_addr = 2'(a); #1;
         chk(bus_rdata == '0, "R11 reset register", int'(bus_rdata), 0);
      end
      chk(irq_flag == 0 && uf_strobe == 0, "R11 reset outputs", int'(irq_flag), 0);
      #1; rst_n = 1;
      // R7 stopped writes load both
      wr(0, 2); wr(1, 3);
      peek(0, v); chk(v == 2, "R7 stopped prescaler load", v, 2);
      peek(1, v); chk(v == 3, "R7 stopped main load", v, 3);
      // R1 R3 every-clock source: period 3*4
      wr(2, 8'h01);
      gap_chk(12, "R3 period every clock");
      // R1 half-rate source
      wr(2, 8'h05);
      gap_chk(24, "R1 half-rate period");
      // R1 eighth-rate source
      wr(2, 8'h09);
      gap_chk(96, "R1 eighth-rate period");
      // R1 external pulses
      wr(2, 8'h0D);
      pulse_ext(30, 2);
      // R4 stop holds
      wr(2, 8'h10);
      peek(0, v); peek(1, v2);
      idle(20);
      peek(0, v); chk(v == int'(bus_rdata), "R4 hold prescaler", int'(bus_rdata), v);
      peek(1, v); chk(v == v2, "R4 hold main", v, v2);
      // R5 clear with bit4 = 1 keeps, bit4 = 0 clears
      chk(irq_flag == 1, "R5 irq kept by bit4=1", int'(irq_flag), 1);
      wr(2, 8'h00);
      chk(irq_flag == 0, "R5 irq cleared", int'(irq_flag), 0);
      // R9 reload-only writes while running
      wr(2, 8'h03);
      wr(0, 1); idle(10); wr(1, 5);
      gap_chk(12, "R9 new reload period");
      // R8 R10 pipelined writes while running
      wr(2, 8'h01);
      wr(1, 2);
      chk(irq_flag == 1, "R10 spurious irq", int'(irq_flag), 1);
      idle(1); wr(0, 3); idle(6);
      wr(0, 0); wr(1, 1);
      gap_chk(2, "R8 pipelined values in force");
      idle(10);
      // R8 pipelined under external source
      wr(2, 8'h0D);
      wr(0, 4);
      pulse_ext(2, 3);
      wr(1, 0);
      pulse_ext(12, 1);
      wr(2, 8'h00);
      idle(5);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule